// File: doc/BRIEF.md
# Receive Descriptor Ring Fill Engine

This block is the hardware side of a circular receive descriptor ring. Each ring entry holds a 4-bit ownership code and one payload word. Software owns the codes through a host port. It marks entries ready, reads back the codes and payloads, and hands entries back. The engine keeps a current-entry pointer. Whenever the current entry is marked ready and a frame is waiting, the engine stores the frame there, marks the entry as holding data, and moves the pointer forward one place.

Frames arrive one word per cycle and first go into a small local FIFO. If the engine finds the current entry not ready, it raises an error interrupt and stops. Frames that keep arriving build up in the FIFO. When the FIFO is full, a separate RAM-full interrupt is raised, and any further arrivals are dropped and counted. A restart pulse from software resumes filling at the entry after the rejected one. The rejected entry is always skipped, which leaves a hole that software has to step over.

Top module: `rx_ring_fill`

## Requirements
- R1: After reset the current pointer is 0, the engine is running, the status bits, the drop counter and the FIFO level are all zero, and every entry code reads 0xF (not in use).
- R2: When the engine is running, the FIFO holds a frame and the current entry's code is 0xA (empty), the engine does four things at one clock edge: it stores the oldest frame in that entry, sets the code to 0x4 (full), advances the pointer by one, and pulses `done_pulse` for exactly the following cycle.
- R3: After index DEPTH-1 the pointer wraps to 0. `nxt_idx` always equals the current pointer plus one, modulo DEPTH.
- R4: When the engine is running and a frame is waiting, but the current entry's code is anything other than 0xA, the engine halts. It sets status bit 0 (error), keeps the pointer on the rejected entry and leaves the frame in the FIFO.
- R5: A restart pulse while halted clears the halt and moves the pointer to the rejected entry plus one. This happens even if software has made the rejected entry 0xA again. A restart pulse while running has no effect.
- R6: The FIFO holds up to FIFO_DEPTH frames in arrival order. A frame is accepted unless the FIFO already holds FIFO_DEPTH frames at that edge. `fifo_level` reports the occupancy.
- R7: On any edge at which the FIFO holds FIFO_DEPTH frames, status bit 1 (RAM full) and status bit 0 (error) are both set.
- R8: A frame that is not accepted increments a DROP_W-bit counter. The counter saturates at its all-ones value.
- R9: Status bits are sticky. A 1 in `sts_clr` clears the matching bit, a set in the same cycle wins over a clear, and `irq` is the OR of the status bits.
- R10: A host write to the entry the engine fills in the same cycle wins: the entry ends up with the host's code, and the pointer still advances.
- R11: `hst_rcode` and `hst_rdata` show, without a clock delay, the code and the last stored payload of the entry addressed by `hst_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A frame word is offered this cycle |
| in_data | input | DATA_W | Frame word |
| hst_we | input | 1 | Host write of an entry code |
| hst_addr | input | AW | Host entry index for write and read |
| hst_wcode | input | 4 | Code to write |
| hst_rcode | output | 4 | Code of the addressed entry |
| hst_rdata | output | DATA_W | Payload of the addressed entry |
| restart | input | 1 | Resume pulse after a halt |
| sts_clr | input | 2 | Write-one-to-clear for the status bits |
| cur_idx | output | AW | Current entry pointer |
| nxt_idx | output | AW | Pointer plus one, modulo DEPTH |
| halted | output | 1 | Engine stopped on a non-empty entry |
| sts | output | 2 | Bit 1 RAM full, bit 0 error |
| irq | output | 1 | Any status bit set |
| done_pulse | output | 1 | One-cycle pulse per entry filled |
| drop_cnt | output | DROP_W | Saturating count of dropped frames |
| fifo_level | output | LW | Frames waiting in the local FIFO |

## Verification
The bench builds the block with an 8-entry ring and a 4-frame FIFO. With these values the ring wraps within a few frames, so a halt on an entry that is still full is easy to reach. Overflow then follows after a handful of frames arrive while halted, which exercises skip-on-resume, the RAM-full interrupt and the set-beats-clear rule. DROP_W stays at 16, so a long flood while halted drives the drop counter all the way to saturation.

// File: rtl/rx_ring_fill.sv
module rx_ring_fill #(
  parameter int DEPTH      = 256,
  parameter int FIFO_DEPTH = 4,
  parameter int DATA_W     = 32,
  parameter int DROP_W     = 16,
  localparam int AW  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int FAW = (FIFO_DEPTH > 1) ? $clog2(FIFO_DEPTH) : 1,
  localparam int LW  = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic              hst_we,
  input  logic [AW-1:0]     hst_addr,
  input  logic [3:0]        hst_wcode,
  output logic [3:0]        hst_rcode,
  output logic [DATA_W-1:0] hst_rdata,
  input  logic              restart,
  input  logic [1:0]        sts_clr,
  output logic [AW-1:0]     cur_idx,
  output logic [AW-1:0]     nxt_idx,
  output logic              halted,
  output logic [1:0]        sts,
  output logic              irq,
  output logic              done_pulse,
  output logic [DROP_W-1:0] drop_cnt,
  output logic [LW-1:0]     fifo_level
);
  localparam logic [3:0] C_EMPTY = 4'hA;
  localparam logic [3:0] C_FULL  = 4'h4;
  localparam logic [3:0] C_IDLE  = 4'hF;

  logic [3:0]        code_q [DEPTH];
  logic [DATA_W-1:0] data_q [DEPTH];
  logic [DATA_W-1:0] fq     [FIFO_DEPTH];
  logic [FAW-1:0]    rd_q, wr_q;
  logic [AW-1:0]     cur_q;
  logic [LW-1:0]     lvl_q;
  logic              halt_q, done_q;
  logic [1:0]        sts_q;
  logic [DROP_W-1:0] drop_q;

  function automatic logic [AW-1:0] ring_inc(input logic [AW-1:0] x);
    return (x == AW'(DEPTH - 1)) ? '0 : x + AW'(1);
  endfunction

  function automatic logic [FAW-1:0] fifo_inc(input logic [FAW-1:0] x);
    return (x == FAW'(FIFO_DEPTH - 1)) ? '0 : x + FAW'(1);
  endfunction

  wire fifo_full = (lvl_q == LW'(FIFO_DEPTH));
  wire take      = !halt_q && (lvl_q != '0);
  wire fill      = take && (code_q[cur_q] == C_EMPTY);
  wire reject    = take && !fill;
  wire push      = in_valid && !fifo_full;
  wire drop      = in_valid && fifo_full;
  wire resume    = restart && halt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) code_q[i] <= C_IDLE;
    end else begin
      if (fill)   code_q[cur_q]    <= C_FULL;
      if (hst_we) code_q[hst_addr] <= hst_wcode;
    end
  end

  always_ff @(posedge clk) begin
    if (fill) data_q[cur_q] <= fq[rd_q];
    if (push) fq[wr_q] <= in_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q   <= '0;
      wr_q   <= '0;
      lvl_q  <= '0;
      cur_q  <= '0;
      halt_q <= 1'b0;
      done_q <= 1'b0;
      sts_q  <= '0;
      drop_q <= '0;
    end else begin
      if (fill) rd_q <= fifo_inc(rd_q);
      if (push) wr_q <= fifo_inc(wr_q);
      lvl_q <= lvl_q + LW'(push) - LW'(fill);
      if (fill || resume) cur_q <= ring_inc(cur_q);
      if (reject)      halt_q <= 1'b1;
      else if (resume) halt_q <= 1'b0;
      done_q <= fill;
      sts_q  <= (sts_q & ~sts_clr) | {fifo_full, reject | fifo_full};
      if (drop && (drop_q != '1)) drop_q <= drop_q + DROP_W'(1);
    end
  end

  assign hst_rcode  = code_q[hst_addr];
  assign hst_rdata  = data_q[hst_addr];
  assign cur_idx    = cur_q;
  assign nxt_idx    = ring_inc(cur_q);
  assign halted     = halt_q;
  assign sts        = sts_q;
  assign irq        = |sts_q;
  assign done_pulse = done_q;
  assign drop_cnt   = drop_q;
  assign fifo_level = lvl_q;
endmodule

// File: rtl/rx_ring_fill_chk.sv
module rx_ring_fill_chk #(
  parameter int DEPTH      = 256,
  parameter int FIFO_DEPTH = 4,
  parameter int DROP_W     = 16,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LW = $clog2(FIFO_DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [AW-1:0]     cur_idx,
  input logic              halted,
  input logic [1:0]        sts,
  input logic              done_pulse,
  input logic [DROP_W-1:0] drop_cnt,
  input logic [LW-1:0]     fifo_level
);
  // R2
  fill_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |-> cur_idx == (($past(cur_idx) == AW'(DEPTH - 1)) ? AW'(0) : AW'($past(cur_idx) + 1)));
  // R2
  fill_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |-> !$past(halted));
  // R4
  halt_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(halted) |-> sts[0]);
  // R4
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && $past(halted)) |-> $stable(cur_idx));
  // R6
  level_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_level <= LW'(FIFO_DEPTH));
  // R7
  ramfull_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts[1]) |-> sts[0]);
  // R8
  drop_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drop_cnt >= $past(drop_cnt));
endmodule

bind rx_ring_fill rx_ring_fill_chk #(.DEPTH(DEPTH), .FIFO_DEPTH(FIFO_DEPTH), .DROP_W(DROP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cur_idx(cur_idx), .halted(halted), .sts(sts),
  .done_pulse(done_pulse), .drop_cnt(drop_cnt), .fifo_level(fifo_level));

// File: tb/rx_ring_fill_bench.sv
module rx_ring_fill_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 8;
  localparam int FD = 4;
  localparam int DW = 16;
  localparam int AW = 3;
  localparam int LW = 3;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, hst_we = 0, restart = 0;
  logic [DW-1:0] in_data = '0;
  logic [AW-1:0] hst_addr = '0;
  logic [3:0] hst_wcode = '0;
  logic [1:0] sts_clr = '0;
  logic [3:0] hst_rcode;
  logic [DW-1:0] hst_rdata;
  logic [AW-1:0] cur_idx, nxt_idx;
  logic halted, irq, done_pulse;
  logic [1:0] sts;
  logic [15:0] drop_cnt;
  logic [LW-1:0] fifo_level;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_ring_fill #(.DEPTH(DEPTH), .FIFO_DEPTH(FD), .DATA_W(DW), .DROP_W(16)) u_rx_ring_fill (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .hst_we(hst_we), .hst_addr(hst_addr), .hst_wcode(hst_wcode),
    .hst_rcode(hst_rcode), .hst_rdata(hst_rdata), .restart(restart),
    .sts_clr(sts_clr), .cur_idx(cur_idx), .nxt_idx(nxt_idx), .halted(halted),
    .sts(sts), .irq(irq), .done_pulse(done_pulse), .drop_cnt(drop_cnt),
    .fifo_level(fifo_level));

  int m_code [DEPTH];
  int m_data [DEPTH];
  bit m_dv [DEPTH];
  int q [$];
  int m_cur, m_sts, m_drop;
  bit m_halt, m_done;
  int nchk = 0, nerr = 0;
  int o_cur;
  bit o_halt, t_fill, t_rej, t_full;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin m_code[i] = 15; m_dv[i] = 0; end
      q.delete();
      m_cur = 0; m_sts = 0; m_drop = 0; m_halt = 0; m_done = 0;
    end else begin
      o_cur = m_cur; o_halt = m_halt;
      t_full = (q.size() == FD);
      t_fill = !o_halt && q.size() > 0 && m_code[o_cur] == 10;
      t_rej  = !o_halt && q.size() > 0 && m_code[o_cur] != 10;
      if (t_fill) begin
        m_data[o_cur] = q[0]; m_dv[o_cur] = 1; m_code[o_cur] = 4;
        void'(q.pop_front());
        m_cur = (o_cur + 1) % DEPTH;
      end
      if (t_rej) m_halt = 1;
      else if (restart && o_halt) begin m_halt = 0; m_cur = (o_cur + 1) % DEPTH; end
      if (hst_we) m_code[hst_addr] = hst_wcode;
      if (in_valid) begin
        if (t_full) begin if (m_drop < 65535) m_drop++; end
        else q.push_back(in_data);
      end
      m_sts = (m_sts & ~int'(sts_clr)) | (t_full ? 3 : 0) | (t_rej ? 1 : 0);
      m_done = t_fill;
    end
  end

  task automatic chk(input string r, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", r, act, exp, $time);
    end
  endtask

  task automatic compare();
    chk("R2 cur_idx", int'(cur_idx), m_cur);
    chk("R3 nxt_idx", int'(nxt_idx), (m_cur + 1) % DEPTH);
    chk("R4 halted", int'(halted), int'(m_halt));
    chk("R9 sts", int'(sts), m_sts);
    chk("R9 irq", int'(irq), int'(m_sts != 0));
    chk("R2 done_pulse", int'(done_pulse), int'(m_done));
    chk("R8 drop_cnt", int'(drop_cnt), m_drop);
    chk("R6 fifo_level", int'(fifo_level), q.size());
    chk("R11 hst_rcode", int'(hst_rcode), m_code[hst_addr]);
    if (m_dv[hst_addr]) chk("R11 hst_rdata", int'(hst_rdata), m_data[hst_addr]);
  endtask

  task automatic cyc();
    @(negedge clk);
    compare();
  endtask

  task automatic idle();
    in_valid = 0; hst_we = 0; restart = 0; sts_clr = 0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nerr);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nerr++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 cur_idx", int'(cur_idx), 0);
    chk("R1 halted", int'(halted), 0);
    chk("R1 sts", int'(sts), 0);
    chk("R1 drop_cnt", int'(drop_cnt), 0);
    chk("R1 fifo_level", int'(fifo_level), 0);
    chk("R1 code", int'(hst_rcode), 15);
    rst_n = 1;
    for (int i = 0; i < DEPTH; i++) begin
      hst_we = 1; hst_addr = AW'(i); hst_wcode = 4'hA; cyc();
    end
    idle(); hst_addr = 3'd5; cyc();
    chk("R11 code readback", int'(hst_rcode), 10);

    for (int k = 0; k < 3; k++) begin
      in_valid = 1; in_data = DW'(16'h100 + k); cyc();
      in_valid = 0; cyc(); cyc();
    end
    hst_addr = 3'd1; cyc();
    chk("R2 pointer after three frames", int'(cur_idx), 3);
    chk("R2 stored payload", int'(hst_rdata), 16'h101);
    chk("R2 full code", int'(hst_rcode), 4);

    for (int k = 0; k < 5; k++) begin
      in_valid = 1; in_data = DW'(16'h200 + k); cyc();
    end
    in_valid = 0; cyc(); cyc();
    chk("R3 wrap to zero", int'(cur_idx), 0);

    in_valid = 1; in_data = 16'h300; cyc();
    in_valid = 0; cyc(); cyc();
    chk("R4 halt on full entry", int'(halted), 1);
    chk("R4 pointer on rejected", int'(cur_idx), 0);
    chk("R4 error bit", int'(sts[0]), 1);

    for (int k = 0; k < 6; k++) begin
      in_valid = 1; in_data = DW'(16'h400 + k); cyc();
    end
    in_valid = 0; cyc();
    chk("R7 ram full status", int'(sts), 3);
    chk("R8 drops while full", int'(drop_cnt), 3);
    sts_clr = 2'b11; cyc(); sts_clr = 0; cyc();
    chk("R9 set beats clear while full", int'(sts), 3);

    for (int i = 0; i < DEPTH; i++) begin
      hst_we = 1; hst_addr = AW'(i); hst_wcode = 4'hA; cyc();
    end
    hst_we = 0; restart = 1; cyc();
    restart = 0;
    chk("R5 resume past rejected", int'(cur_idx), 1);
    chk("R5 halt cleared", int'(halted), 0);
    repeat (6) cyc();
    hst_addr = 3'd0; cyc();
    chk("R5 rejected entry skipped", int'(hst_rcode), 10);
    chk("R6 fifo drained in order", int'(cur_idx), 5);
    sts_clr = 2'b11; cyc(); sts_clr = 0; cyc();
    chk("R9 cleared", int'(sts), 0);
    restart = 1; cyc(); restart = 0; cyc();
    chk("R5 restart while running ignored", int'(cur_idx), 5);

    in_valid = 1; in_data = 16'h555; cyc();
    in_valid = 0; hst_we = 1; hst_addr = 3'd5; hst_wcode = 4'hF; cyc();
    hst_we = 0; cyc();
    chk("R10 host code wins", int'(hst_rcode), 15);
    chk("R10 pointer still advances", int'(cur_idx), 6);

    for (int n = 0; n < 3000; n++) begin
      in_valid = ($urandom_range(1) == 1);
      in_data = DW'($urandom);
      hst_we = ($urandom_range(4) == 0);
      hst_addr = AW'($urandom_range(DEPTH - 1));
      case ($urandom_range(4))
        0: hst_wcode = 4'h4;
        1: hst_wcode = 4'hF;
        default: hst_wcode = 4'hA;
      endcase
      restart = ($urandom_range(19) == 0);
      sts_clr = ($urandom_range(9) == 0) ? 2'($urandom) : 2'b00;
      cyc();
    end
    idle();

    for (int n = 0; n < 50 && !m_halt; n++) begin
      hst_we = 1; hst_addr = AW'(m_cur); hst_wcode = 4'hF; in_valid = 1; cyc();
    end
    hst_we = 0;
    chk("R4 halted before flood", int'(halted), 1);
    in_valid = 1;
    for (int n = 0; n < 65545; n++) cyc();
    in_valid = 0; cyc();
    chk("R8 saturated drop count", int'(drop_cnt), 65535);

    summary();
    $finish;
  end
endmodule